// File: doc/BRIEF.md
# Shared-Slave Bus Arbiter with Idle Parking

This block decides which of `N_MST` bus masters owns a single shared slave port. Every master raises `req` while it wants the slave and marks the final beat of its access with `last`. An access ends in the cycle where the owner's `req` and `last` are both high, or in the first owned cycle where the owner's `req` is low. The block drives a one-hot grant `gnt` and the index of the connected master `gnt_idx`. Both come straight from registers, so a master that is already connected is served in the same cycle it asks, and any other master is served one cycle after it asks. Arbitration is either round-robin or fixed priority. A slot-cycle limit lets a waiting master break a long burst.

When no connected master is waiting, an idle policy chooses what the slave stays attached to. It can disconnect. It can stay with the last owner. It can attach to a configured master. A parameter mask, `CONNECTED`, lists which masters are wired to this slave. Requests from masters outside the mask are dropped.

The control is a three-state machine:
- `ST_IDLE`: no master is connected.
- `ST_PARK`: a master is connected but not transferring.
- `ST_BUSY`: the owner holds the slave for an access.

The transitions are as follows:
- **arbitrate**: moves to `ST_BUSY` with a new owner from any state when a candidate exists.
- **continue**: `ST_PARK`/`ST_BUSY` to `ST_BUSY` with the same owner, while an unfinished access goes on.
- **preempt**: moves to `ST_BUSY` with a new owner when the slot limit is reached and another master waits.
- **park**: moves to `ST_PARK` when an access ends with nobody waiting and the policy keeps a master attached.
- **release**: moves to `ST_IDLE` when the policy disconnects.

Top module: `bus_slot_arbiter`

## Requirements
- R1: `gnt` has at most one bit set. When a bit is set, `gnt_idx` is that bit's index. When no bit is set, `gnt_idx` is 0. Both are 0 after reset.
- R2: With `cfg_park_mode` = 0 (value 3 acts the same), the grant drops to all zeros in the cycle after an access ends with no other connected request. A later request then sees its grant one cycle after it is raised.
- R3: With `cfg_park_mode` = 1, the last owner stays granted after its access ends with no other connected request. Its next request is granted in the same cycle.
- R4: With `cfg_park_mode` = 2 and `cfg_park_id` naming a connected master, the slave attaches to that master one cycle after no connected request is present, including from the disconnected state. That master is then granted in the same cycle it requests.
- R5: With `cfg_park_mode` = 2 and `cfg_park_id` naming a master whose `CONNECTED` bit is 0, behaviour is that of mode 0.
- R6: A master that is not connected and wins arbitration is granted one cycle after its request. Requests from masters outside `CONNECTED` never produce a grant.
- R7: With `cfg_fixed_prio` = 1, the lowest-numbered waiting master wins. The owner whose access just ended is excluded.
- R8: With `cfg_fixed_prio` = 0, the search starts at the index after the last arbitration winner and wraps around.
- R9: With `cfg_slot_limit` = L > 0, an owner that has held the slave with `req` high for L cycles hands over in the next cycle if another connected master is waiting.
- R10: The slot count restarts at every change of ownership. With nobody else waiting, an access may run past L cycles, and it is preempted in the cycle after a competitor appears.
- R11: `cfg_slot_limit` = 0 means no limit: an access is never broken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_MST | Per-master request, held for the whole access |
| last | input | N_MST | Per-master final-beat marker |
| cfg_fixed_prio | input | 1 | 0 round-robin, 1 fixed priority |
| cfg_park_mode | input | 2 | 0 disconnect, 1 stay on last owner, 2 attach to `cfg_park_id` |
| cfg_park_id | input | IDX_W | Master to attach to in mode 2 |
| cfg_slot_limit | input | SLOT_W | Owned cycles before a burst may be broken, 0 = unlimited |
| gnt | output | N_MST | One-hot grant |
| gnt_idx | output | IDX_W | Index of the connected master |

## Verification
The bench builds the block with four masters, an 8-bit slot counter and `CONNECTED` = 4'b0111. Master 3 therefore exists on the ports but is not wired to the slave. This lets the bench show that master 3's requests are dropped, and that a park target of 3 falls back to disconnecting. Slot limits of 3 and 0 keep preemption, the counter restart and unlimited bursts within a few dozen cycles. Owner and competitor pairs are chosen so that round-robin and fixed priority pick different winners.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PARK = 2'd1,
        ST_BUSY = 2'd2
    } arb_state_e;

    localparam logic [1:0] PARK_NONE  = 2'd0;
    localparam logic [1:0] PARK_LAST  = 2'd1;
    localparam logic [1:0] PARK_FIXED = 2'd2;

endpackage

// File: rtl/arb_pick.sv
// Winner selection among candidate masters: fixed priority and round-robin
module arb_pick #(
    parameter int N_MST = 4,
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic [N_MST-1:0] cand,
    input  logic [IDX_W-1:0] ptr,
    input  logic             fixed_mode,
    output logic             any,
    output logic [IDX_W-1:0] win
);

    logic [IDX_W-1:0] fix_idx;
    logic [IDX_W-1:0] rr_idx;

    always_comb begin
        fix_idx = '0;
        for (int i = N_MST - 1; i >= 0; i--) begin
            if (cand[i]) fix_idx = IDX_W'(i);
        end
    end

    // scan from ptr+N down to ptr+1 so the nearest index after ptr wins
    always_comb begin
        rr_idx = '0;
        for (int k = N_MST; k >= 1; k--) begin
            int j;
            j = (int'(ptr) + k) % N_MST;
            if (cand[j]) rr_idx = IDX_W'(j);
        end
    end

    assign any = |cand;
    assign win = fixed_mode ? fix_idx : rr_idx;

endmodule

// File: rtl/arb_slot_timer.sv
// Counts owned cycles of the current access; flags when the slot is used up
module arb_slot_timer #(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [SLOT_W-1:0] limit,
    output logic              expired
);

    localparam logic [SLOT_W-1:0] CNT_MAX = '1;

    logic [SLOT_W-1:0] cnt_q;
    logic [SLOT_W:0]   hold;

    // cycles held including the present one
    assign hold    = {1'b0, cnt_q} + 1'b1;
    assign expired = (limit != '0) && (hold >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/bus_slot_arbiter.sv
// Shared-slave arbiter with idle parking policies and burst slot limit
module bus_slot_arbiter
    import arb_pkg::*;
#(
    parameter int               N_MST     = 4,
    parameter int               SLOT_W    = 8,
    parameter logic [N_MST-1:0] CONNECTED = '1,
    localparam int              IDX_W     = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_MST-1:0]  req,
    input  logic [N_MST-1:0]  last,
    input  logic              cfg_fixed_prio,
    input  logic [1:0]        cfg_park_mode,
    input  logic [IDX_W-1:0]  cfg_park_id,
    input  logic [SLOT_W-1:0] cfg_slot_limit,
    output logic [N_MST-1:0]  gnt,
    output logic [IDX_W-1:0]  gnt_idx
);

    localparam logic [N_MST-1:0] ONE = N_MST'(1);

    arb_state_e       state_q, state_d;
    logic [IDX_W-1:0] owner_q, owner_d;
    logic [IDX_W-1:0] rr_q, rr_d;

    logic [N_MST-1:0] owner_oh;
    logic             connected;
    logic             active;
    logic             cont;
    logic [N_MST-1:0] cand;
    logic             pick_any;
    logic [IDX_W-1:0] pick_win;
    logic             slot_expired;
    logic             slot_clr;
    logic             park_ok;
    arb_state_e       park_state;
    logic [IDX_W-1:0] park_owner;
    logic             take;

    assign owner_oh  = ONE << owner_q;
    assign connected = (state_q != ST_IDLE);
    assign active    = connected && req[owner_q];
    assign cont      = active && !last[owner_q];
    assign cand      = req & CONNECTED & (connected ? ~owner_oh : '1);
    assign park_ok   = (int'(cfg_park_id) < N_MST) && CONNECTED[cfg_park_id];

    arb_pick #(.N_MST(N_MST)) u_pick (
        .cand       (cand),
        .ptr        (rr_q),
        .fixed_mode (cfg_fixed_prio),
        .any        (pick_any),
        .win        (pick_win)
    );

    arb_slot_timer #(.SLOT_W(SLOT_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (slot_clr),
        .adv     (active),
        .limit   (cfg_slot_limit),
        .expired (slot_expired)
    );

    // where the slave rests when nobody is waiting
    always_comb begin
        park_state = ST_IDLE;
        park_owner = owner_q;
        if (cfg_park_mode == PARK_LAST && connected) begin
            park_state = ST_PARK;
        end else if (cfg_park_mode == PARK_FIXED && park_ok) begin
            park_state = ST_PARK;
            park_owner = cfg_park_id;
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        rr_d    = rr_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_any) begin
                    take = 1'b1;
                end else begin
                    state_d = park_state;
                    owner_d = park_owner;
                end
            end
            ST_PARK, ST_BUSY: begin
                if (cont) begin
                    if (slot_expired && pick_any) take = 1'b1;
                    else                          state_d = ST_BUSY;
                end else if (pick_any) begin
                    take = 1'b1;
                end else begin
                    state_d = park_state;
                    owner_d = park_owner;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (take) begin
            state_d = ST_BUSY;
            owner_d = pick_win;
            rr_d    = pick_win;
        end
    end

    assign slot_clr = (state_d != ST_BUSY) || (owner_d != owner_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            rr_q    <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            rr_q    <= rr_d;
        end
    end

    // outputs
    always_comb begin
        gnt     = connected ? owner_oh : '0;
        gnt_idx = connected ? owner_q : '0;
    end

endmodule

// File: rtl/arb_chk.sv
// Temporal checks for bus_slot_arbiter
module arb_chk #(
    parameter int               N_MST     = 4,
    parameter int               SLOT_W    = 8,
    parameter logic [N_MST-1:0] CONNECTED = '1,
    localparam int              IDX_W     = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_MST-1:0]  req,
    input logic [N_MST-1:0]  last,
    input logic [1:0]        cfg_park_mode,
    input logic [IDX_W-1:0]  cfg_park_id,
    input logic [SLOT_W-1:0] cfg_slot_limit,
    input logic [N_MST-1:0]  gnt,
    input logic [IDX_W-1:0]  gnt_idx
);

    localparam logic [N_MST-1:0] ONE = N_MST'(1);

    // R1
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R1
    gnt_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) ? gnt[gnt_idx] : (gnt_idx == '0));

    // R2
    park_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_park_mode == 2'd0 && gnt != '0 && (req & gnt) == '0
         && (req & CONNECTED & ~gnt) == '0) |=> (gnt == '0));

    // R3
    park_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_park_mode == 2'd1 && gnt != '0 && (req & gnt) == '0
         && (req & CONNECTED & ~gnt) == '0) |=> $stable(gnt));

    // R4
    park_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_park_mode == 2'd2 && CONNECTED[cfg_park_id] && (req & CONNECTED) == '0)
        |=> (gnt == (ONE << $past(cfg_park_id))));

    // R6
    new_grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && gnt != $past(gnt) && $past(cfg_park_mode) != 2'd2)
        |-> (($past(req) & CONNECTED & gnt) != '0));

    // R11
    no_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_slot_limit == '0 && (req & gnt) != '0 && (last & gnt) == '0)
        |=> $stable(gnt));

endmodule

bind bus_slot_arbiter arb_chk #(
    .N_MST     (N_MST),
    .SLOT_W    (SLOT_W),
    .CONNECTED (CONNECTED)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req            (req),
    .last           (last),
    .cfg_park_mode  (cfg_park_mode),
    .cfg_park_id    (cfg_park_id),
    .cfg_slot_limit (cfg_slot_limit),
    .gnt            (gnt),
    .gnt_idx        (gnt_idx)
);

// File: tb/bus_slot_arbiter_tb.sv
module bus_slot_arbiter_tb;

    localparam int N  = 4;
    localparam int IW = 2;
    localparam int SW = 8;
    localparam logic [N-1:0] CONN = 4'b0111;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  last = '0;
    logic          cfg_fixed_prio = 1'b1;
    logic [1:0]    cfg_park_mode = 2'd0;
    logic [IW-1:0] cfg_park_id = '0;
    logic [SW-1:0] cfg_slot_limit = 8'd16;
    logic [N-1:0]  gnt;
    logic [IW-1:0] gnt_idx;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    bus_slot_arbiter #(.N_MST(N), .SLOT_W(SW), .CONNECTED(CONN)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req            (req),
        .last           (last),
        .cfg_fixed_prio (cfg_fixed_prio),
        .cfg_park_mode  (cfg_park_mode),
        .cfg_park_id    (cfg_park_id),
        .cfg_slot_limit (cfg_slot_limit),
        .gnt            (gnt),
        .gnt_idx        (gnt_idx)
    );

    function automatic logic [IW-1:0] oh_to_idx(input logic [N-1:0] v);
        logic [IW-1:0] r;
        r = '0;
        for (int i = 0; i < N; i++) if (v[i]) r = IW'(i);
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic [N-1:0] r, input logic [N-1:0] l);
        req  = r;
        last = l;
    endtask

    task automatic check(input string tag, input logic [N-1:0] exp);
        logic [IW-1:0] exp_idx;
        exp_idx = oh_to_idx(exp);
        n_chk++;
        if (gnt !== exp || gnt_idx !== exp_idx) begin
            n_err++;
            $display("FAIL %s: gnt=%b idx=%0d expected gnt=%b idx=%0d",
                     tag, gnt, gnt_idx, exp, exp_idx);
        end
    endtask

    task automatic quiesce();
        cfg_park_mode = 2'd0;
        drive('0, '0);
        tick();
        tick();
    endtask

    task automatic t_reset();
        check("R1 reset state", 4'b0000);
    endtask

    task automatic t_disconnect();
        cfg_fixed_prio = 1'b1; cfg_park_mode = 2'd0; cfg_slot_limit = '0;
        drive(4'b0001, 4'b0000);
        check("R6 not granted in request cycle", 4'b0000);
        tick(); check("R6 granted one cycle later", 4'b0001);
        drive(4'b0001, 4'b0001);
        tick(); check("R2 disconnect after single access", 4'b0000);
        drive(4'b0001, 4'b0000);
        check("R2 extra cycle before regrant", 4'b0000);
        tick(); check("R2 regrant", 4'b0001);
        drive('0, '0);
        tick(); check("R2 release when request drops", 4'b0000);
        quiesce();
    endtask

    task automatic t_park_last();
        cfg_park_mode = 2'd1;
        drive(4'b0010, 4'b0000);
        tick(); check("R3 first grant", 4'b0010);
        drive('0, '0);
        tick(); check("R3 parked on last owner", 4'b0010);
        tick(); check("R3 still parked", 4'b0010);
        drive(4'b0010, 4'b0010);
        check("R3 zero-latency grant", 4'b0010);
        tick(); check("R3 stays after last beat", 4'b0010);
        drive(4'b0100, 4'b0000);
        tick(); check("R3 parked slave handed over", 4'b0100);
        quiesce();
    endtask

    task automatic t_park_fixed();
        cfg_park_mode = 2'd2; cfg_park_id = 2'd2;
        drive('0, '0);
        tick(); check("R4 attach from idle", 4'b0100);
        drive(4'b0100, 4'b0100);
        check("R4 zero-latency grant", 4'b0100);
        tick(); check("R4 stays after access", 4'b0100);
        drive(4'b0001, 4'b0000);
        tick(); check("R4 other master served", 4'b0001);
        drive('0, '0);
        tick(); check("R4 return to fixed master", 4'b0100);
        quiesce();
    endtask

    task automatic t_park_bad();
        cfg_park_mode = 2'd2; cfg_park_id = 2'd3;
        drive('0, '0);
        tick(); check("R5 no attach to unconnected id", 4'b0000);
        tick(); check("R5 remains disconnected", 4'b0000);
        drive(4'b0001, 4'b0000);
        check("R5 extra cycle", 4'b0000);
        tick(); check("R5 grant", 4'b0001);
        drive(4'b0001, 4'b0001);
        tick(); check("R5 disconnect after access", 4'b0000);
        quiesce();
    endtask

    task automatic t_unconnected();
        drive(4'b1000, 4'b0000);
        tick(); check("R6 unconnected request ignored", 4'b0000);
        tick(); check("R6 unconnected request still ignored", 4'b0000);
        drive(4'b0001, 4'b0000);
        tick(); check("R6 connected master granted", 4'b0001);
        drive(4'b1001, 4'b0001);
        tick(); check("R6 unconnected not a competitor", 4'b0000);
        quiesce();
    endtask

    task automatic t_fixed();
        cfg_fixed_prio = 1'b1; cfg_slot_limit = '0;
        drive(4'b0001, 4'b0000);
        tick(); check("R7 owner", 4'b0001);
        drive(4'b0111, 4'b0001);
        tick(); check("R7 lowest waiting other", 4'b0010);
        drive(4'b0101, 4'b0010);
        tick(); check("R7 lowest index wins", 4'b0001);
        quiesce();
    endtask

    task automatic t_rr();
        cfg_fixed_prio = 1'b0; cfg_slot_limit = '0;
        drive(4'b0010, 4'b0000);
        tick(); check("R8 owner", 4'b0010);
        drive(4'b0111, 4'b0010);
        tick(); check("R8 search after last winner", 4'b0100);
        drive(4'b0011, 4'b0100);
        tick(); check("R8 search wraps", 4'b0001);
        quiesce();
        cfg_fixed_prio = 1'b1;
    endtask

    task automatic t_slot();
        cfg_fixed_prio = 1'b1; cfg_slot_limit = 8'd3;
        drive(4'b0001, 4'b0000);
        tick(); check("R9 owner cycle 1", 4'b0001);
        drive(4'b0011, 4'b0000);
        tick(); check("R9 owner cycle 2", 4'b0001);
        tick(); check("R9 owner cycle 3", 4'b0001);
        tick(); check("R9 preempt after limit", 4'b0010);
        tick(); check("R10 new owner cycle 2", 4'b0010);
        tick(); check("R10 new owner cycle 3 after restart", 4'b0010);
        tick(); check("R9 handed back", 4'b0001);
        drive(4'b0001, 4'b0000);
        for (int i = 0; i < 5; i++) begin
            tick(); check("R10 burst continues past limit", 4'b0001);
        end
        drive(4'b0011, 4'b0000);
        tick(); check("R10 preempt once competitor appears", 4'b0010);
        quiesce();
    endtask

    task automatic t_nolimit();
        cfg_fixed_prio = 1'b1; cfg_slot_limit = '0;
        drive(4'b0001, 4'b0000);
        tick(); check("R11 owner", 4'b0001);
        drive(4'b0011, 4'b0000);
        for (int i = 0; i < 20; i++) begin
            tick(); check("R11 burst never broken", 4'b0001);
        end
        drive(4'b0011, 4'b0001);
        tick(); check("R11 handover at last beat", 4'b0010);
        quiesce();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_disconnect();
        t_park_last();
        t_park_fixed();
        t_park_bad();
        t_unconnected();
        t_fixed();
        t_rr();
        t_slot();
        t_nolimit();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule